// File: doc/BRIEF.md
# Precision Time-of-Day Counter

This block keeps a running time of day for a precision time protocol port: 48 bits of seconds and 30 bits of nanoseconds. Each clock it advances by a fixed nominal increment of 8 ns. A signed fractional rate trim, held as a 30-bit magnitude with a direction flag, is accumulated below the nanosecond. Each time that accumulator overflows, the increment for that cycle gains or loses one nanosecond. The live time is driven out on two ports so that a timestamp capture block can latch it.

Software reaches the block through a small space of 16-bit words. Set-time words, step words and rate-trim words are written first. A write to the command word then acts on them. One command word carries one-shot bits to clear, stop, start, snapshot, load, step seconds and step nanoseconds. A snapshot copies the whole time into five read words in a single cycle, so reading them back gives a coherent value. Every command bit acts only in the cycle the command word is written. Nothing needs clearing afterwards.

Top module: `ptp_time_counter`

Word addresses (4 bits): 0 command; 1, 2, 3 set-seconds bits 47:32, 31:16, 15:0; 4 set-nanoseconds bits 29:16 (in 13:0); 5 set-nanoseconds bits 15:0; 6 step-low; 7 step-high; 8 rate-high; 9 rate-low; 10, 11, 12 snapshot seconds bits 47:32, 31:16, 15:0; 13 snapshot nanoseconds bits 29:16 (in 13:0); 14 snapshot nanoseconds bits 15:0. Reads of any other address return zero.

## Requirements
- R1: After the reset input is asserted, the time is 0 s 0 ns, the counter is stopped, the rate trim is zero, and all five snapshot words read zero.
- R2: A command write with bit 4 set loads the time from the set words on that clock edge. It also clears the fractional accumulator.
- R3: While running with zero trim, each clock edge adds INC_NS (8) nanoseconds to the time.
- R4: Nanoseconds always stay below NS_PER_SEC. On reaching it they wrap, and one second is carried into the seconds count.
- R5: Command bit 5 steps the seconds by step-low bits 3:0; the upper step-low bits are ignored. Step-high bit 15 set means add and clear means subtract. A subtraction below zero wraps modulo 2^48.
- R6: While stopped, the time holds its value unless a command changes it.
- R7: Command bit 6 adds the 30-bit value {step-high bits 13:0, step-low} to the nanoseconds, always forward, carrying into seconds on rollover. Step-high bit 15 has no effect on this step.
- R8: The rate trim magnitude is {rate-high bits 13:0, rate-low}. It is added each running cycle to a 32-bit accumulator in units of 2^-32 ns. On each carry one nanosecond is added if rate-high bit 15 is set and removed if it is clear.
- R9: Command bit 3 copies seconds and nanoseconds into the snapshot words on one edge. Those words then stay fixed until the next snapshot.
- R10: Command bit 0 clears the time, the rate trim and the accumulator, and stops the counter. It overrides every other bit of the same command.
- R11: Command bit 2 starts the counter and bit 1 stops it. When both are set, the counter stops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counter clock, one nominal increment per edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Word write strobe |
| wr_addr | input | 4 | Word address for a write |
| wr_data | input | 16 | Write data |
| rd_addr | input | 4 | Word address for a read |
| rd_data | output | 16 | Read data, combinational from rd_addr |
| tod_sec | output | 48 | Live seconds |
| tod_ns | output | 30 | Live nanoseconds |

## Verification
The bench builds the block with NS_PER_SEC set to 1000 and the other parameters at their defaults. This brings a seconds carry from normal counting, and a nanosecond step across a rollover, within a few dozen cycles. A rate magnitude of 2^29 gives exactly one trim carry every eight cycles, so any sixteen-cycle window shows exactly two extra or missing nanoseconds whatever the accumulator phase. Seconds underflow is reached by stepping down from a small loaded value.

// File: rtl/ptp_time_counter.sv
`timescale 1ns/100ps
module ptp_time_counter #(
  parameter int NS_PER_SEC = 1000000000,
  parameter int INC_NS     = 8,
  parameter int FRAC_W     = 32,
  parameter int STEP_SEC_W = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [3:0]  wr_addr,
  input  logic [15:0] wr_data,
  input  logic [3:0]  rd_addr,
  output logic [15:0] rd_data,
  output logic [47:0] tod_sec,
  output logic [29:0] tod_ns
);
  localparam int SEC_W  = 48;
  localparam int NS_W   = 30;
  localparam int RATE_W = 30;

  localparam logic [3:0] A_CMD = 4'd0, A_SSH = 4'd1, A_SSM = 4'd2, A_SSL = 4'd3,
                         A_SNH = 4'd4, A_SNL = 4'd5, A_STL = 4'd6, A_STH = 4'd7,
                         A_RTH = 4'd8, A_RTL = 4'd9, A_QSH = 4'd10, A_QSM = 4'd11,
                         A_QSL = 4'd12, A_QNH = 4'd13, A_QNL = 4'd14;

  logic [SEC_W-1:0]  sec_q, set_sec, snap_sec;
  logic [NS_W-1:0]   ns_q, set_ns, snap_ns;
  logic [15:0]       step_lo, step_hi;
  logic [RATE_W-1:0] rate_mag;
  logic              rate_fast, run_q;
  logic [FRAC_W-1:0] frac_q;

  wire cmd_hit = wr_en && (wr_addr == A_CMD);
  wire c_clr   = cmd_hit && wr_data[0];
  wire c_stop  = cmd_hit && wr_data[1];
  wire c_go    = cmd_hit && wr_data[2];
  wire c_snap  = cmd_hit && wr_data[3];
  wire c_load  = cmd_hit && wr_data[4];
  wire c_stps  = cmd_hit && wr_data[5];
  wire c_stpn  = cmd_hit && wr_data[6];

  wire [FRAC_W:0] frac_sum = {1'b0, frac_q} + (FRAC_W+1)'(rate_mag);
  wire            trim_c   = run_q && frac_sum[FRAC_W];

  logic [NS_W:0] inc_val;
  always_comb begin
    if (!run_q)      inc_val = '0;
    else if (!trim_c) inc_val = (NS_W+1)'(INC_NS);
    else if (rate_fast) inc_val = (NS_W+1)'(INC_NS + 1);
    else             inc_val = (NS_W+1)'(INC_NS - 1);
  end

  wire [NS_W-1:0] ns_add  = c_stpn ? {step_hi[13:0], step_lo} : '0;
  wire [NS_W:0]   ns_sum  = {1'b0, ns_q} + inc_val + {1'b0, ns_add};
  wire            ns_wrap = ns_sum >= (NS_W+1)'(NS_PER_SEC);
  wire [NS_W:0]   ns_red  = ns_wrap ? ns_sum - (NS_W+1)'(NS_PER_SEC) : ns_sum;

  wire [SEC_W-1:0] step_mag = SEC_W'(step_lo[STEP_SEC_W-1:0]);
  wire [SEC_W-1:0] sec_dlt  = !c_stps ? '0 : (step_hi[15] ? step_mag : (~step_mag + 1'b1));
  wire [SEC_W-1:0] sec_nxt  = sec_q + sec_dlt + SEC_W'(ns_wrap);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sec_q <= '0; ns_q <= '0; frac_q <= '0; run_q <= 1'b0;
      set_sec <= '0; set_ns <= '0; step_lo <= '0; step_hi <= '0;
      rate_mag <= '0; rate_fast <= 1'b0; snap_sec <= '0; snap_ns <= '0;
    end else begin
      if (wr_en) begin
        case (wr_addr)
          A_SSH: set_sec[47:32] <= wr_data;
          A_SSM: set_sec[31:16] <= wr_data;
          A_SSL: set_sec[15:0]  <= wr_data;
          A_SNH: set_ns[29:16]  <= wr_data[13:0];
          A_SNL: set_ns[15:0]   <= wr_data;
          A_STL: step_lo        <= wr_data;
          A_STH: step_hi        <= wr_data;
          A_RTH: begin rate_fast <= wr_data[15]; rate_mag[29:16] <= wr_data[13:0]; end
          A_RTL: rate_mag[15:0] <= wr_data;
          default: ;
        endcase
      end
      if (c_snap) begin
        snap_sec <= sec_q;
        snap_ns  <= ns_q;
      end
      if (c_clr) begin
        sec_q <= '0; ns_q <= '0; frac_q <= '0; run_q <= 1'b0;
        rate_mag <= '0; rate_fast <= 1'b0;
      end else begin
        if (c_stop)    run_q <= 1'b0;
        else if (c_go) run_q <= 1'b1;
        if (c_load) begin
          sec_q <= set_sec; ns_q <= set_ns; frac_q <= '0;
        end else begin
          sec_q <= sec_nxt;
          ns_q  <= ns_red[NS_W-1:0];
          if (run_q) frac_q <= frac_sum[FRAC_W-1:0];
        end
      end
    end
  end

  always_comb begin
    case (rd_addr)
      A_QSH:   rd_data = snap_sec[47:32];
      A_QSM:   rd_data = snap_sec[31:16];
      A_QSL:   rd_data = snap_sec[15:0];
      A_QNH:   rd_data = {2'b00, snap_ns[29:16]};
      A_QNL:   rd_data = snap_ns[15:0];
      default: rd_data = '0;
    endcase
  end

  assign tod_sec = sec_q;
  assign tod_ns  = ns_q;

  assert_ns_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ns_q < NS_W'(NS_PER_SEC));

  assert_hold_stopped_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !cmd_hit) |=> ($stable(ns_q) && $stable(sec_q)));

  assert_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (c_load && !c_clr) |=> (sec_q == $past(set_sec) && ns_q == $past(set_ns)));

  assert_snap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    c_snap |=> (snap_sec == $past(sec_q) && snap_ns == $past(ns_q)));

  assert_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !cmd_hit && rate_mag == '0 && ns_q < NS_W'(NS_PER_SEC - INC_NS))
      |=> ns_q == $past(ns_q) + NS_W'(INC_NS));

  assert_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    c_clr |=> (sec_q == '0 && ns_q == '0 && rate_mag == '0 && !run_q));
endmodule

// File: tb/tb_ptp_time_counter.sv
`timescale 1ns/100ps
module tb_ptp_time_counter;
  localparam int NSPS = 1000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [3:0]  rd_addr = '0;
  logic [15:0] rd_data;
  logic [47:0] tod_sec;
  logic [29:0] tod_ns;

  int total = 0;
  int bad = 0;
  bit done = 0;

  ptp_time_counter #(.NS_PER_SEC(NSPS)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .tod_sec(tod_sec), .tod_ns(tod_ns));

  always #5 clk = ~clk;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] d);
    rd_addr = a;
    #0.2;
    d = rd_data;
  endtask

  task automatic read_snap(output logic [47:0] s, output logic [29:0] n);
    logic [15:0] w0, w1, w2, w3, w4;
    rd(4'd10, w0); rd(4'd11, w1); rd(4'd12, w2); rd(4'd13, w3); rd(4'd14, w4);
    s = {w0, w1, w2};
    n = {w3[13:0], w4};
  endtask

  task automatic snap(output logic [47:0] s, output logic [29:0] n);
    wr(4'd0, 16'h0008);
    read_snap(s, n);
  endtask

  function automatic logic [63:0] tot(input logic [47:0] s, input logic [29:0] n);
    return 64'(s) * NSPS + 64'(n);
  endfunction

  task automatic load(input logic [47:0] s, input logic [29:0] n);
    wr(4'd1, s[47:32]); wr(4'd2, s[31:16]); wr(4'd3, s[15:0]);
    wr(4'd4, {2'b00, n[29:16]}); wr(4'd5, n[15:0]);
    wr(4'd0, 16'h0010);
  endtask

  // window of n edges between two snapshots
  task automatic diff_window(input int n, output logic [63:0] d);
    logic [47:0] s0, s1;
    logic [29:0] n0, n1;
    snap(s0, n0);
    repeat (n - 2) @(negedge clk);
    snap(s1, n1);
    d = tot(s1, n1) - tot(s0, n0);
  endtask

  task automatic t_reset;
    logic [47:0] s; logic [29:0] n;
    chk("R1 tod_sec", tod_sec, 0);
    chk("R1 tod_ns", tod_ns, 0);
    read_snap(s, n);
    chk("R1 snap words", {s, n} == 0, 1);
    repeat (4) @(negedge clk);
    chk("R1 stopped after reset", tod_ns, 0);
  endtask

  task automatic t_load_hold;
    logic [47:0] s; logic [29:0] n;
    load(48'h0001_2345_6789, 30'd500);
    repeat (6) @(negedge clk);
    snap(s, n);
    chk("R2 load sec", s, 48'h0001_2345_6789);
    chk("R2 load ns", n, 500);
    chk("R6 hold while stopped", tod_ns, 500);
  endtask

  task automatic t_step_sec;
    logic [47:0] s; logic [29:0] n;
    wr(4'd6, 16'h0005); wr(4'd7, 16'h8000); wr(4'd0, 16'h0020);
    wr(4'd6, 16'h0013); wr(4'd7, 16'h0000); wr(4'd0, 16'h0020);
    snap(s, n);
    chk("R5 add 5 then subtract 3 (upper bits ignored)", s, 48'h0001_2345_678B);
    chk("R5 ns untouched", n, 500);
    load(48'd2, 30'd0);
    wr(4'd6, 16'h0005); wr(4'd0, 16'h0020);
    snap(s, n);
    chk("R5 underflow wraps", s, 48'hFFFF_FFFF_FFFD);
  endtask

  task automatic t_step_ns;
    logic [47:0] s; logic [29:0] n;
    load(48'd7, 30'd990);
    wr(4'd6, 16'd20); wr(4'd7, 16'h0000); wr(4'd0, 16'h0040);
    snap(s, n);
    chk("R7 ns step rollover sec", s, 8);
    chk("R7 ns step rollover ns", n, 10);
    wr(4'd6, 16'd5); wr(4'd7, 16'h8000); wr(4'd0, 16'h0040);
    snap(s, n);
    chk("R7 direction bit ignored", n, 15);
  endtask

  task automatic t_run;
    logic [63:0] d;
    logic [47:0] s; logic [29:0] n;
    wr(4'd0, 16'h0004);
    diff_window(10, d);
    chk("R3 ten edges", d, 80);
    load(48'd3, 30'd960);
    snap(s, n);
    chk("R2 load while running", tot(s, n), 3 * NSPS + 968);
    repeat (8) @(negedge clk);
    snap(s, n);
    chk("R4 carry sec", s, 4);
    chk("R4 wrapped ns", n, 48);
  endtask

  task automatic t_rate;
    logic [63:0] d;
    wr(4'd9, 16'h0000); wr(4'd8, 16'hA000);
    load(48'd0, 30'd0);
    diff_window(16, d);
    chk("R8 faster trim", d, 130);
    wr(4'd8, 16'h2000);
    diff_window(16, d);
    chk("R8 slower trim", d, 126);
    wr(4'd8, 16'h0000);
    diff_window(16, d);
    chk("R8 zero trim", d, 128);
  endtask

  task automatic t_coherent;
    logic [47:0] s0, s1; logic [29:0] n0, n1, live;
    snap(s0, n0);
    live = tod_ns;
    repeat (20) @(negedge clk);
    read_snap(s1, n1);
    chk("R9 snapshot frozen", {s1, n1} == {s0, n0}, 1);
    chk("R9 live time moved", tod_ns != live, 1);
  endtask

  task automatic t_stop;
    logic [29:0] n; logic [47:0] s;
    wr(4'd0, 16'h0002);
    n = tod_ns; s = tod_sec;
    repeat (10) @(negedge clk);
    chk("R6 stopped holds", {tod_sec, tod_ns} == {s, n}, 1);
    wr(4'd0, 16'h0006);
    n = tod_ns;
    repeat (10) @(negedge clk);
    chk("R11 stop wins over start", tod_ns, n);
  endtask

  task automatic t_clear;
    logic [63:0] d;
    wr(4'd8, 16'hA000);
    wr(4'd0, 16'h0004);
    repeat (5) @(negedge clk);
    wr(4'd0, 16'h0015);
    chk("R10 time cleared", {tod_sec, tod_ns} == 0, 1);
    repeat (5) @(negedge clk);
    chk("R10 stopped after clear", {tod_sec, tod_ns} == 0, 1);
    wr(4'd0, 16'h0004);
    diff_window(16, d);
    chk("R10 trim cleared", d, 128);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_load_hold();
    t_step_sec();
    t_step_ns();
    t_run();
    t_rate();
    t_coherent();
    t_stop();
    t_clear();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #200000;
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule